// File: doc/BRIEF.md
# Strap-Addressed Indirect Management Register Responder

This block sits on the slave side of a management serial link, after the bit-level deserializer. Each decoded frame arrives as a single-cycle strobe carrying a 5-bit device address, a 5-bit register number, a direction flag and 16 bits of write data. The block turns frames into accesses on an internal fixed-latency register bus that reaches a bank of sub-devices. It returns read results on a response strobe, together with a flag that says whether the data line is driven.

Four strap inputs set the device address. They form address bits 4:1, and bit 0 is always zero. An all-zero strap selects direct mode. In direct mode every one of the 32 device addresses is passed straight through as the internal sub-device number. Any non-zero strap selects shared mode. In shared mode the block answers only at its strapped address and only through two window registers, a command register and a data register. All internal traffic then goes through these two registers, and a busy flag can be polled.

An internal access occupies the engine for a fixed, parameterised number of cycles. The bus read data must be valid in the last of those cycles, so the parameter must be at least 2.

Top module: `mgmt_indirect_resp`

## Requirements
- R1: After reset there is no response strobe and no bus request. In shared mode, a read of the command register returns 0x0000 and a read of the data register returns 0x0000.
- R2: The strapped address is {strap_i, 1'b0}. A strap of zero selects direct mode and any other value selects shared mode.
- R3: In direct mode, a frame to device P and register R starts one bus access to sub-device P, register R. For a write frame the access is a write that carries the frame data.
- R4: In direct mode, the response to a read frame sampled at clock edge E1 is valid for the one cycle after edge E1+ACC_CYCLES. It is driven and carries the bus read data.
- R5: In shared mode, these frames are ignored: frames to any address other than the strapped one, and frames to registers 2 to 31 at the strapped address. A read of this kind gets a response with drive low and data 0xFFFF. A write of this kind changes no state and starts no access.
- R6: In shared mode, register 0 is the command register and register 1 is the data register. A command word has the opcode in bits 11:10 (01 = write, 10 = read), the sub-device in bits 9:5 and the register in bits 4:0. A read of the command register returns busy in bit 15, zeros in bits 14:12 and the last accepted command in bits 11:0.
- R7: An accepted command sets busy. Busy stays high for exactly ACC_CYCLES cycles and then clears.
- R8: An indirect write stores the data register's current value into the target internal register.
- R9: An indirect read places the bus read data in the data register at the edge where busy clears.
- R10: While busy is high, writes to the command register and to the data register are ignored. A command with opcode 00 or 11 is never accepted.
- R11: In shared mode, a read of a window register is answered in the cycle after the frame edge, with drive high.
- R12: In direct mode, a frame that arrives while an access is in progress is dropped: no bus access and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_i | input | 4 | Address strap, forms address bits 4:1 |
| frame_valid_i | input | 1 | One-cycle strobe for a decoded frame |
| frame_phy_i | input | 5 | Device address of the frame |
| frame_reg_i | input | 5 | Register number of the frame |
| frame_wr_i | input | 1 | 1 = write frame, 0 = read frame |
| frame_wdata_i | input | 16 | Write data of the frame |
| rsp_valid_o | output | 1 | One-cycle read response strobe |
| rsp_drive_o | output | 1 | Data line is driven for this response |
| rsp_rdata_o | output | 16 | Read response data |
| bus_req_o | output | 1 | Internal access request, one cycle |
| bus_we_o | output | 1 | Internal access is a write |
| bus_dev_o | output | 5 | Internal sub-device number |
| bus_reg_o | output | 5 | Internal register number |
| bus_wdata_o | output | 16 | Internal write data |
| bus_rdata_i | input | 16 | Internal read data, valid in the last access cycle |

## Verification
Two kinds of result have different timing. Window reads and ignored reads respond in the cycle after the frame edge. Direct reads respond only after the internal access has finished. The bench changes inputs on falling edges, and consecutive frame tasks sample on consecutive rising edges, so the edge that produces each result is known in advance. Direct-read checks wait exactly ACC_CYCLES cycles after the frame and also confirm that the response was absent one cycle earlier. Busy is checked for its exact length by reading the command register at edge E1+ACC_CYCLES, where busy must still read high, and at the following edge, where it must read low.

// File: rtl/mir_pkg.sv
package mir_pkg;
  localparam int unsigned FIELD_W  = 5;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned STRAP_W  = FIELD_W - 1;
  localparam int unsigned CMD_W    = 12;
  localparam logic [FIELD_W-1:0] REG_CMD  = 5'd0;
  localparam logic [FIELD_W-1:0] REG_DATA = 5'd1;

  typedef enum logic [1:0] {
    OP_NOP0  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_NOP3  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    FR_NONE,
    FR_DIRECT,
    FR_WIN_CMD,
    FR_WIN_DATA,
    FR_IGNORE
  } frame_e;
endpackage

// File: rtl/mir_strap_decode.sv
module mir_strap_decode
  import mir_pkg::*;
(
  input  logic [STRAP_W-1:0] strap_i,
  output logic               direct_o,
  output logic [FIELD_W-1:0] own_addr_o
);
  assign direct_o   = (strap_i == '0);
  assign own_addr_o = {strap_i, 1'b0};
endmodule

// File: rtl/mir_frame_classify.sv
module mir_frame_classify
  import mir_pkg::*;
(
  input  logic               valid_i,
  input  logic               direct_i,
  input  logic [FIELD_W-1:0] own_addr_i,
  input  logic [FIELD_W-1:0] phy_i,
  input  logic [FIELD_W-1:0] reg_i,
  output frame_e             cls_o
);
  always_comb begin
    cls_o = FR_NONE;
    if (valid_i) begin
      if (direct_i)                 cls_o = FR_DIRECT;
      else if (phy_i != own_addr_i) cls_o = FR_IGNORE;
      else if (reg_i == REG_CMD)    cls_o = FR_WIN_CMD;
      else if (reg_i == REG_DATA)   cls_o = FR_WIN_DATA;
      else                          cls_o = FR_IGNORE;
    end
  end
endmodule

// File: rtl/mir_access_engine.sv
module mir_access_engine
  import mir_pkg::*;
#(
  parameter int unsigned ACC_CYCLES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               we_i,
  input  logic [FIELD_W-1:0] dev_i,
  input  logic [FIELD_W-1:0] reg_i,
  input  logic [WORD_W-1:0]  wdata_i,
  output logic               busy_o,
  output logic               done_rd_o,
  output logic               bus_req_o,
  output logic               bus_we_o,
  output logic [FIELD_W-1:0] bus_dev_o,
  output logic [FIELD_W-1:0] bus_reg_o,
  output logic [WORD_W-1:0]  bus_wdata_o
);
  localparam int unsigned CNT_W = $clog2(ACC_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACC_CYCLES - 1);

  logic               busy_q, req_q, we_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FIELD_W-1:0] dev_q, reg_q;
  logic [WORD_W-1:0]  wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      cnt_q   <= '0;
      dev_q   <= '0;
      reg_q   <= '0;
      wdata_q <= '0;
    end else begin
      req_q <= 1'b0;
      if (start_i) begin
        busy_q  <= 1'b1;
        req_q   <= 1'b1;
        cnt_q   <= CNT_LOAD;
        we_q    <= we_i;
        dev_q   <= dev_i;
        reg_q   <= reg_i;
        wdata_q <= wdata_i;
      end else if (busy_q) begin
        if (cnt_q == '0) busy_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o      = busy_q;
  assign done_rd_o   = busy_q && (cnt_q == '0) && !we_q;
  assign bus_req_o   = req_q;
  assign bus_we_o    = we_q;
  assign bus_dev_o   = dev_q;
  assign bus_reg_o   = reg_q;
  assign bus_wdata_o = wdata_q;

  a_r7_req_inside_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> busy_o);
  a_r7_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> busy_q);
  a_r10_start_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
endmodule

// File: rtl/mir_window_regs.sv
module mir_window_regs
  import mir_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_wr_i,
  input  logic               data_wr_i,
  input  logic [WORD_W-1:0]  wdata_i,
  input  logic               busy_i,
  input  logic               rd_done_i,
  input  logic [WORD_W-1:0]  rdata_i,
  output logic [WORD_W-1:0]  cmd_view_o,
  output logic [WORD_W-1:0]  data_o,
  output logic               start_o,
  output logic               start_we_o,
  output logic [FIELD_W-1:0] tgt_dev_o,
  output logic [FIELD_W-1:0] tgt_reg_o
);
  logic [CMD_W-1:0]  cmd_q;
  logic [WORD_W-1:0] data_q;
  op_e               op;
  logic              cmd_ok;

  assign op     = op_e'(wdata_i[11:10]);
  assign cmd_ok = cmd_wr_i && !busy_i && (op == OP_WRITE || op == OP_READ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (cmd_ok) cmd_q <= wdata_i[CMD_W-1:0];
      if (rd_done_i)                data_q <= rdata_i;
      else if (data_wr_i && !busy_i) data_q <= wdata_i;
    end
  end

  assign cmd_view_o = {busy_i, {(WORD_W-CMD_W-1){1'b0}}, cmd_q};
  assign data_o     = data_q;
  assign start_o    = cmd_ok;
  assign start_we_o = (op == OP_WRITE);
  assign tgt_dev_o  = wdata_i[9:5];
  assign tgt_reg_o  = wdata_i[4:0];

  a_r10_cmd_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(cmd_q));
  a_r10_data_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !rd_done_i) |=> $stable(data_q));
endmodule

// File: rtl/mgmt_indirect_resp.sv
module mgmt_indirect_resp
  import mir_pkg::*;
#(
  parameter int unsigned ACC_CYCLES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [3:0]          strap_i,
  input  logic                frame_valid_i,
  input  logic [4:0]          frame_phy_i,
  input  logic [4:0]          frame_reg_i,
  input  logic                frame_wr_i,
  input  logic [15:0]         frame_wdata_i,
  output logic                rsp_valid_o,
  output logic                rsp_drive_o,
  output logic [15:0]         rsp_rdata_o,
  output logic                bus_req_o,
  output logic                bus_we_o,
  output logic [4:0]          bus_dev_o,
  output logic [4:0]          bus_reg_o,
  output logic [15:0]         bus_wdata_o,
  input  logic [15:0]         bus_rdata_i
);
  logic               direct;
  logic [FIELD_W-1:0] own_addr;
  frame_e             cls;
  logic               busy, done_rd;
  logic               win_start, win_we;
  logic [FIELD_W-1:0] win_dev, win_reg;
  logic [WORD_W-1:0]  cmd_view, data_reg;
  logic               eng_start, eng_we;
  logic [FIELD_W-1:0] eng_dev, eng_reg;
  logic [WORD_W-1:0]  eng_wdata;
  logic               rsp_valid_q, rsp_drive_q;
  logic [WORD_W-1:0]  rsp_data_q;

  mir_strap_decode i_strap (
    .strap_i    (strap_i),
    .direct_o   (direct),
    .own_addr_o (own_addr)
  );

  mir_frame_classify i_classify (
    .valid_i    (frame_valid_i),
    .direct_i   (direct),
    .own_addr_i (own_addr),
    .phy_i      (frame_phy_i),
    .reg_i      (frame_reg_i),
    .cls_o      (cls)
  );

  mir_window_regs i_window (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_wr_i   (cls == FR_WIN_CMD && frame_wr_i),
    .data_wr_i  (cls == FR_WIN_DATA && frame_wr_i),
    .wdata_i    (frame_wdata_i),
    .busy_i     (busy),
    .rd_done_i  (done_rd && !direct),
    .rdata_i    (bus_rdata_i),
    .cmd_view_o (cmd_view),
    .data_o     (data_reg),
    .start_o    (win_start),
    .start_we_o (win_we),
    .tgt_dev_o  (win_dev),
    .tgt_reg_o  (win_reg)
  );

  // direct frames pass straight through; shared mode uses the window command
  always_comb begin
    if (direct) begin
      eng_start = (cls == FR_DIRECT) && !busy;
      eng_we    = frame_wr_i;
      eng_dev   = frame_phy_i;
      eng_reg   = frame_reg_i;
      eng_wdata = frame_wdata_i;
    end else begin
      eng_start = win_start;
      eng_we    = win_we;
      eng_dev   = win_dev;
      eng_reg   = win_reg;
      eng_wdata = data_reg;
    end
  end

  mir_access_engine #(.ACC_CYCLES(ACC_CYCLES)) i_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (eng_start),
    .we_i        (eng_we),
    .dev_i       (eng_dev),
    .reg_i       (eng_reg),
    .wdata_i     (eng_wdata),
    .busy_o      (busy),
    .done_rd_o   (done_rd),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_dev_o   (bus_dev_o),
    .bus_reg_o   (bus_reg_o),
    .bus_wdata_o (bus_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_drive_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      rsp_drive_q <= 1'b0;
      if (direct && done_rd) begin
        rsp_valid_q <= 1'b1;
        rsp_drive_q <= 1'b1;
        rsp_data_q  <= bus_rdata_i;
      end else if (!frame_wr_i) begin
        unique case (cls)
          FR_WIN_CMD: begin
            rsp_valid_q <= 1'b1;
            rsp_drive_q <= 1'b1;
            rsp_data_q  <= cmd_view;
          end
          FR_WIN_DATA: begin
            rsp_valid_q <= 1'b1;
            rsp_drive_q <= 1'b1;
            rsp_data_q  <= data_reg;
          end
          FR_IGNORE: begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= '1;
          end
          default: ;
        endcase
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_drive_o = rsp_drive_q;
  assign rsp_rdata_o = rsp_data_q;

  a_r5_float_all_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_drive_o) |-> (rsp_rdata_o == 16'hFFFF));
  a_r12_one_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (direct && busy) |-> !eng_start);
endmodule

// File: tb/test_mgmt_indirect_resp.sv
module test_mgmt_indirect_resp;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  strap = 4'd0;
  logic        fv = 1'b0;
  logic [4:0]  fphy = '0, freg = '0;
  logic        fwr = 1'b0;
  logic [15:0] fwd = '0;
  logic        rsp_valid, rsp_drive;
  logic [15:0] rsp_rdata;
  logic        bus_req, bus_we;
  logic [4:0]  bus_dev, bus_reg;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = '0;

  int tests = 0, fails = 0, bank_acc = 0;
  logic [15:0] mem [0:1023];
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mgmt_indirect_resp #(.ACC_CYCLES(N)) i_mgmt_indirect_resp (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(strap),
    .frame_valid_i(fv), .frame_phy_i(fphy), .frame_reg_i(freg),
    .frame_wr_i(fwr), .frame_wdata_i(fwd),
    .rsp_valid_o(rsp_valid), .rsp_drive_o(rsp_drive), .rsp_rdata_o(rsp_rdata),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_dev_o(bus_dev),
    .bus_reg_o(bus_reg), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata)
  );

  function automatic logic [15:0] init_val(int dev, int rg);
    return 16'((dev * 32 + rg) * 37) ^ 16'hA5C3;
  endfunction

  // bank model: one-cycle read latency
  initial for (int i = 0; i < 1024; i++) mem[i] = init_val(i / 32, i % 32);
  always @(posedge clk) begin
    if (bus_req) begin
      bank_acc++;
      if (bus_we) mem[{bus_dev, bus_reg}] <= bus_wdata;
      else        bus_rdata <= mem[{bus_dev, bus_reg}];
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_rsp(string req, logic drv, logic [15:0] d);
    chk({req, " valid"}, 32'(rsp_valid), 32'd1);
    chk({req, " drive"}, 32'(rsp_drive), 32'(drv));
    chk({req, " data"}, 32'(rsp_rdata), 32'(d));
  endtask

  task automatic frame(logic wr, logic [4:0] phy, logic [4:0] rg, logic [15:0] d);
    fv = 1'b1; fwr = wr; fphy = phy; freg = rg; fwd = d;
    @(negedge clk);
    fv = 1'b0; fwr = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(logic [3:0] s);
    strap = s; rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  function automatic logic [15:0] cmdw(logic [1:0] op, int dev, int rg);
    return {4'b0, op, 5'(dev), 5'(rg)};
  endfunction

  task automatic t_reset;
    do_reset(4'd3);
    chk("R1 rsp idle", 32'(rsp_valid), 0);
    chk("R1 bus idle", 32'(bus_req), 0);
    frame(0, 5'd6, 5'd0, 0); chk_rsp("R1 cmd reset", 1, 16'h0000);
    frame(0, 5'd6, 5'd1, 0); chk_rsp("R1 data reset", 1, 16'h0000);
  endtask

  task automatic t_direct_map;
    int p[5] = '{0, 1, 7, 16, 31};
    do_reset(4'd0);
    foreach (p[k]) begin
      int rg = p[k] ^ 5;
      frame(0, 5'(p[k]), 5'(rg), 0);
      idle(N - 1);
      chk("R4 not early", 32'(rsp_valid), 0);
      idle(1);
      chk_rsp("R3 R4 direct read", 1, init_val(p[k], rg));
      idle(1);
    end
  endtask

  task automatic t_direct_write;
    frame(1, 5'd9, 5'd2, 16'hBEEF);
    idle(N);
    chk("R3 bank write", 32'(mem[9*32+2]), 32'hBEEF);
    frame(0, 5'd9, 5'd2, 0);
    idle(N);
    chk_rsp("R3 readback", 1, 16'hBEEF);
    idle(1);
  endtask

  task automatic t_direct_drop;
    int a0;
    a0 = bank_acc;
    frame(1, 5'd4, 5'd4, 16'h1111);
    frame(1, 5'd5, 5'd5, 16'h2222);
    idle(N);
    chk("R12 one access", 32'(bank_acc - a0), 1);
    chk("R12 dropped write", 32'(mem[5*32+5]), 32'(init_val(5, 5)));
    frame(0, 5'd4, 5'd4, 0);
    frame(0, 5'd6, 5'd6, 0);
    idle(N - 1);
    chk_rsp("R12 first read", 1, 16'h1111);
    idle(1);
    chk("R12 no second rsp", 32'(rsp_valid), 0);
    idle(N);
    chk("R12 still no rsp", 32'(rsp_valid), 0);
  endtask

  task automatic t_shared_write;
    do_reset(4'd3);
    frame(1, 5'd6, 5'd1, 16'h1234);
    frame(1, 5'd6, 5'd0, cmdw(2'b01, 10, 3));
    idle(N - 1);
    frame(0, 5'd6, 5'd0, 0);
    chk_rsp("R7 busy last cycle", 1, {1'b1, 3'b0, cmdw(2'b01, 10, 3)[11:0]});
    frame(0, 5'd6, 5'd0, 0);
    chk_rsp("R6 R7 busy cleared", 1, {4'b0, cmdw(2'b01, 10, 3)[11:0]});
    chk("R8 indirect write", 32'(mem[10*32+3]), 32'h1234);
  endtask

  task automatic t_shared_read;
    frame(1, 5'd6, 5'd0, cmdw(2'b10, 2, 7));
    frame(0, 5'd6, 5'd0, 0);
    chk_rsp("R11 R7 busy seen", 1, {1'b1, 3'b0, cmdw(2'b10, 2, 7)[11:0]});
    idle(N);
    frame(0, 5'd6, 5'd1, 0);
    chk_rsp("R9 read result", 1, init_val(2, 7));
  endtask

  task automatic t_busy_ignore;
    int a0;
    frame(1, 5'd6, 5'd1, 16'h7777);
    a0 = bank_acc;
    frame(1, 5'd6, 5'd0, cmdw(2'b01, 1, 1));
    frame(1, 5'd6, 5'd1, 16'hAAAA);
    frame(1, 5'd6, 5'd0, cmdw(2'b10, 3, 3));
    idle(N);
    chk("R10 one access", 32'(bank_acc - a0), 1);
    chk("R10 write used old data", 32'(mem[1*32+1]), 32'h7777);
    frame(0, 5'd6, 5'd0, 0);
    chk_rsp("R10 cmd kept", 1, {4'b0, cmdw(2'b01, 1, 1)[11:0]});
    frame(0, 5'd6, 5'd1, 0);
    chk_rsp("R10 data kept", 1, 16'h7777);
  endtask

  task automatic t_bad_opcode;
    int a0;
    a0 = bank_acc;
    frame(1, 5'd6, 5'd0, cmdw(2'b00, 4, 4));
    frame(0, 5'd6, 5'd0, 0);
    chk_rsp("R10 op00 rejected", 1, {4'b0, cmdw(2'b01, 1, 1)[11:0]});
    frame(1, 5'd6, 5'd0, cmdw(2'b11, 4, 4));
    frame(0, 5'd6, 5'd0, 0);
    chk_rsp("R10 op11 rejected", 1, {4'b0, cmdw(2'b01, 1, 1)[11:0]});
    idle(N);
    chk("R10 no access", 32'(bank_acc - a0), 0);
  endtask

  task automatic t_ignore;
    int a0;
    a0 = bank_acc;
    frame(0, 5'd7, 5'd0, 0); chk_rsp("R5 odd addr", 0, 16'hFFFF);
    frame(0, 5'd6, 5'd2, 0); chk_rsp("R5 reg 2", 0, 16'hFFFF);
    frame(0, 5'd0, 5'd0, 0); chk_rsp("R5 addr 0", 0, 16'hFFFF);
    frame(1, 5'd6, 5'd9, 16'h5555);
    frame(1, 5'd4, 5'd1, 16'h5555);
    frame(1, 5'd2, 5'd0, cmdw(2'b01, 8, 8));
    frame(0, 5'd6, 5'd0, 0);
    chk_rsp("R5 cmd untouched", 1, {4'b0, cmdw(2'b01, 1, 1)[11:0]});
    frame(0, 5'd6, 5'd1, 0);
    chk_rsp("R5 data untouched", 1, 16'h7777);
    chk("R5 no access", 32'(bank_acc - a0), 0);
  endtask

  task automatic t_strap_other;
    do_reset(4'd8);
    frame(1, 5'd16, 5'd1, 16'h0F0F);
    frame(0, 5'd16, 5'd1, 0);
    chk_rsp("R2 addr 16 data", 1, 16'h0F0F);
    frame(0, 5'd6, 5'd1, 0);
    chk_rsp("R2 old addr ignored", 0, 16'hFFFF);
  endtask

  initial begin
    idle(2);
    t_reset();
    t_direct_map();
    t_direct_write();
    t_direct_drop();
    t_shared_write();
    t_shared_read();
    t_busy_ignore();
    t_bad_opcode();
    t_ignore();
    t_strap_other();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule